// File: doc/BRIEF.md
# Key-Protected Low-Speed Clock Selector

This block chooses which low-speed clock drives the timekeeping logic. There are two sources. One is an external crystal. The other is the block's own RC clock, divided by 32. Software controls the choice through one control register, and it can change a field only when the write carries a 16-bit unlock key. The block also drives the enable of the external oscillator. It checks that the external oscillator is alive by watching its rising edges against the RC clock, which also clocks the block itself.

When the crystal stops while it is selected, the block moves the selection back to the RC path on its own and sets a sticky flag. A bypass bit in the control register blocks this fallback. A status register reports whether the crystal is alive and whether a fallback has happened.

The glitch-free mux cell is outside this block. It is driven by the select output.

Top module: `lsclk_select`

## Requirements
- R1: A write to the control register (address 0) changes no field unless bits 31:16 of the write data equal 0x16AA. Writes to the status register need no key.
- R2: Control bit 0 is the source select (1 = external crystal, 0 = divided RC path). It drives `src_sel` and reads back at bit 0.
- R3: Control bit 4 is the crystal enable. It drives `xtal_osc_en`, reads back at bit 4, and changes only through a keyed control write.
- R4: After reset, the control register reads 0 (RC path selected, crystal off, fallback armed with bit 15 = 0), and the status register reads 0.
- R5: `rc_div_clk` is the RC clock divided by 32. It is low for the first 16 cycles after reset and high for the next 16, and this repeats.
- R6: Status bit 0 (`xtal_ok`) is 1 when the crystal is enabled, at least one synchronized rising edge has been seen since it was enabled, and the last such edge came less than 64 RC cycles ago. It is 0 while the crystal is disabled.
- R7: Suppose bit 15 is 0, bit 0 is 1, and 64 RC cycles pass without a crystal edge. On the next cycle the hardware clears bit 0 and sets the sticky status bit 1.
- R8: With bit 15 set, a crystal failure still clears status bit 0, but it leaves bit 0 and status bit 1 unchanged.
- R9: Writing status with bit 1 = 1 clears the sticky flag. Writing 0 there leaves it unchanged. A fallback in the same cycle keeps the flag set.
- R10: Control bits 9:7 read back the three `upd_busy` inputs (pending alarm, time and date updates). Writes to these bits have no effect.
- R11: `clk_valid` is `xtal_ok` while the crystal is selected, and 1 while the RC path is selected.
- R12: A keyed control write in the same cycle as a pending fallback wins. The written select value is kept and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal RC clock; clocks the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_clk | input | 1 | External crystal clock, sampled as data |
| upd_busy | input | 3 | Pending-update flags shown in control bits 9:7 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control, 1 = status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| src_sel | output | 1 | Source select to the clock mux |
| xtal_osc_en | output | 1 | Enable for the external oscillator |
| rc_div_clk | output | 1 | RC clock divided by 32 |
| xtal_ok | output | 1 | Crystal alive indication |
| clk_valid | output | 1 | Selected source is good |

## Verification
The crystal is driven with three patterns: toggling steadily (one rise every 8 cycles), stopped low, and stopped with the bypass set. Each pattern separates a different response. A live crystal must keep `xtal_ok` high. A stopped crystal must trigger the timeout and the fallback. A stopped crystal with bypass set must drop `xtal_ok` but keep the selection.

Keyed and unkeyed writes with identical low bits tell key checking apart from plain decoding. A keyed write issued in the exact cycle after the timeout shows whether the software write takes priority over the fallback. A behavioural model compares every output on every cycle, so timing slips of a single cycle in the synchronizer or the timeout window show up as miscompares.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
  localparam logic [15:0] UNLOCK_KEY   = 16'h16AA;
  localparam int unsigned SEL_BIT      = 0;
  localparam int unsigned OSCEN_BIT    = 4;
  localparam int unsigned BUSY_LSB     = 7;
  localparam int unsigned BUSY_W       = 3;
  localparam int unsigned BYPASS_BIT   = 15;
  localparam int unsigned ST_OK_BIT    = 0;
  localparam int unsigned ST_FLAG_BIT  = 1;

  typedef struct packed {
    logic bypass;
    logic osc_en;
    logic sel;
  } ctrl_t;
endpackage

// File: rtl/lsclk_prescaler.sv
module lsclk_prescaler #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic div_out
);
  localparam int unsigned CW = $clog2(DIV);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign div_out = cnt[CW-1];
endmodule

// File: rtl/lsclk_xtal_mon.sv
module lsclk_xtal_mon #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOSS_LIMIT  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_clk,
  input  logic osc_en,
  output logic lost,
  output logic alive
);
  localparam int unsigned CW = $clog2(LOSS_LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LOSS_LIMIT - 1);

  // synchronizer stages plus one history flop for the edge
  logic [SYNC_STAGES:0] shr;
  logic                 rise;
  logic [CW-1:0]        idle_cnt;
  logic                 seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shr <= '0;
    else        shr <= {shr[SYNC_STAGES-1:0], xtal_clk};
  end

  assign rise = shr[SYNC_STAGES-1] & ~shr[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      lost     <= 1'b0;
      seen     <= 1'b0;
    end else if (!osc_en) begin
      idle_cnt <= '0;
      lost     <= 1'b0;
      seen     <= 1'b0;
    end else if (rise) begin
      idle_cnt <= '0;
      lost     <= 1'b0;
      seen     <= 1'b1;
    end else if (idle_cnt == LAST) begin
      lost     <= 1'b1;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign alive = seen & ~lost;
endmodule

// File: rtl/lsclk_ctrl_regs.sv
module lsclk_ctrl_regs
  import lsclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        lost,
  output ctrl_t       ctrl,
  output logic        sw_flag
);
  logic key_wr;
  logic stat_wr;
  logic fire;

  assign key_wr  = bus_wr & ~bus_addr & (bus_wdata[31:16] == UNLOCK_KEY);
  assign stat_wr = bus_wr & bus_addr;
  // hardware fallback yields to a keyed write in the same cycle
  assign fire    = lost & ctrl.sel & ~ctrl.bypass & ~key_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (key_wr) begin
      ctrl.sel    <= bus_wdata[SEL_BIT];
      ctrl.osc_en <= bus_wdata[OSCEN_BIT];
      ctrl.bypass <= bus_wdata[BYPASS_BIT];
    end else if (fire) begin
      ctrl.sel    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              sw_flag <= 1'b0;
    else if (fire)                           sw_flag <= 1'b1;
    else if (stat_wr && bus_wdata[ST_FLAG_BIT]) sw_flag <= 1'b0;
  end
endmodule

// File: rtl/lsclk_select.sv
module lsclk_select
  import lsclk_pkg::*;
#(
  parameter int unsigned RC_DIV      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOSS_LIMIT  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xtal_clk,
  input  logic [2:0]  upd_busy,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        src_sel,
  output logic        xtal_osc_en,
  output logic        rc_div_clk,
  output logic        xtal_ok,
  output logic        clk_valid
);
  ctrl_t ctrl;
  logic  sw_flag;
  logic  xtal_lost;
  logic  bypass;

  lsclk_prescaler #(.DIV(RC_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_out (rc_div_clk)
  );

  lsclk_xtal_mon #(.SYNC_STAGES(SYNC_STAGES), .LOSS_LIMIT(LOSS_LIMIT)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .xtal_clk (xtal_clk),
    .osc_en   (ctrl.osc_en),
    .lost     (xtal_lost),
    .alive    (xtal_ok)
  );

  lsclk_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .lost      (xtal_lost),
    .ctrl      (ctrl),
    .sw_flag   (sw_flag)
  );

  assign src_sel     = ctrl.sel;
  assign xtal_osc_en = ctrl.osc_en;
  assign bypass      = ctrl.bypass;
  assign clk_valid   = ctrl.sel ? xtal_ok : 1'b1;

  always_comb begin
    bus_rdata = '0;
    if (!bus_addr) begin
      bus_rdata[SEL_BIT]                   = ctrl.sel;
      bus_rdata[OSCEN_BIT]                 = ctrl.osc_en;
      bus_rdata[BUSY_LSB +: BUSY_W]        = upd_busy;
      bus_rdata[BYPASS_BIT]                = ctrl.bypass;
    end else begin
      bus_rdata[ST_OK_BIT]                 = xtal_ok;
      bus_rdata[ST_FLAG_BIT]               = sw_flag;
    end
  end
endmodule

// File: rtl/lsclk_select_chk.sv
module lsclk_select_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_addr,
  input logic [31:0] bus_wdata,
  input logic        src_sel,
  input logic        xtal_osc_en,
  input logic        xtal_ok,
  input logic        clk_valid,
  input logic        sw_flag,
  input logic        bypass,
  input logic        xtal_lost
);
  logic keyed;
  assign keyed = bus_wr && !bus_addr && (bus_wdata[31:16] == 16'h16AA);

  // R1: an unkeyed control write leaves the selection alone when no fallback is due
  p_nokey_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && !keyed && clk_valid) |=> $stable(src_sel));

  // R3: the oscillator enable moves only on keyed writes
  p_en_keyed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !keyed |=> $stable(xtal_osc_en));

  // R6: no alive indication one cycle after the crystal is disabled
  p_ok_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_osc_en |=> !xtal_ok);

  // R7: timeout with fallback armed deselects the crystal and sets the flag
  p_failover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xtal_lost && src_sel && !bypass && !keyed) |=> (!src_sel && sw_flag));

  // R8: with bypass set, the selection holds without a write
  p_bypass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !keyed) |=> $stable(src_sel));
endmodule

bind lsclk_select lsclk_select_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .src_sel     (src_sel),
  .xtal_osc_en (xtal_osc_en),
  .xtal_ok     (xtal_ok),
  .clk_valid   (clk_valid),
  .sw_flag     (sw_flag),
  .bypass      (bypass),
  .xtal_lost   (xtal_lost)
);

// File: tb/sim_lsclk_select.sv
`timescale 1ns/1ps
module sim_lsclk_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal_clk = 1'b0;
  logic [2:0]  upd_busy = 3'b000;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        src_sel, xtal_osc_en, rc_div_clk, xtal_ok, clk_valid;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  bit xrun    = 0;

  always #4 clk = ~clk;

  lsclk_select u0 (
    .clk(clk), .rst_n(rst_n), .xtal_clk(xtal_clk), .upd_busy(upd_busy),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_sel(src_sel), .xtal_osc_en(xtal_osc_en),
    .rc_div_clk(rc_div_clk), .xtal_ok(xtal_ok), .clk_valid(clk_valid)
  );

  // ---------------- behavioural reference ----------------
  bit m_sel = 0, m_en = 0, m_byp = 0, m_flag = 0;
  bit m_lost = 0, m_seen = 0;
  int m_quiet = 0;
  int m_cyc = 0;
  bit hist[$] = '{0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_en = 0; m_byp = 0; m_flag = 0;
      m_lost = 0; m_seen = 0; m_quiet = 0; m_cyc = 0;
      hist = '{0, 0, 0};
    end else begin
      bit kw, sw, rise, fire;
      kw   = bus_wr && !bus_addr && (bus_wdata[31:16] == 16'h16AA);
      sw   = bus_wr && bus_addr;
      rise = hist[1] && !hist[2];
      fire = m_lost && m_sel && !m_byp && !kw;
      if (!m_en) begin
        m_quiet = 0; m_lost = 0; m_seen = 0;
      end else if (rise) begin
        m_quiet = 0; m_lost = 0; m_seen = 1;
      end else if (m_quiet == 63) begin
        m_lost = 1;
      end else begin
        m_quiet++;
      end
      if (kw) begin
        m_sel = bus_wdata[0]; m_en = bus_wdata[4]; m_byp = bus_wdata[15];
      end else if (fire) begin
        m_sel = 0;
      end
      if (fire) m_flag = 1;
      else if (sw && bus_wdata[1]) m_flag = 0;
      hist.push_front(xtal_clk);
      void'(hist.pop_back());
      m_cyc++;
    end
  end

  function automatic logic [31:0] exp_rdata();
    bit ok;
    ok = m_seen && !m_lost;
    if (!bus_addr) return {16'd0, m_byp, 5'd0, upd_busy, 2'd0, m_en, 3'd0, m_sel};
    return {30'd0, m_flag, ok};
  endfunction

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // compare every output on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ok;
      ok = m_seen && !m_lost;
      cmp("R2 src_sel", 32'(src_sel), 32'(m_sel));
      cmp("R3 xtal_osc_en", 32'(xtal_osc_en), 32'(m_en));
      cmp("R6 xtal_ok", 32'(xtal_ok), 32'(ok));
      cmp("R11 clk_valid", 32'(clk_valid), 32'(m_sel ? ok : 1'b1));
      cmp("R5 rc_div_clk", 32'(rc_div_clk), 32'((m_cyc % 32) >= 16));
      cmp("R10 bus_rdata", bus_rdata, exp_rdata());
    end
  end

  // crystal: one full period every 8 RC cycles while running
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      if (xrun) begin
        if (ph == 3) begin xtal_clk = ~xtal_clk; ph = 0; end
        else ph++;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(string req, logic a, logic [31:0] exp);
    bus_addr = a;
    #1;
    cmp(req, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R4 reset state
    rd_chk("R4 ctrl after reset", 1'b0, 32'h0);
    rd_chk("R4 status after reset", 1'b1, 32'h0);
    tick(40);                              // R5 covered by per-cycle compare

    // R1 unkeyed write ignored
    xrun = 1;
    wr(1'b0, 32'h1234_8011);
    tick(2);
    rd_chk("R1 unkeyed ctrl write", 1'b0, 32'h0);

    // R2/R3 keyed select of crystal with enable
    wr(1'b0, 32'h16AA_0011);
    tick(40);
    rd_chk("R2 ctrl readback", 1'b0, 32'h0000_0011);
    rd_chk("R6 crystal alive", 1'b1, 32'h1);
    cmp("R11 valid on live crystal", 32'(clk_valid), 32'd1);

    // R10 busy readback, write to those bits ignored
    upd_busy = 3'b101;
    wr(1'b0, 32'h16AA_0391);
    tick(1);
    rd_chk("R10 busy readback", 1'b0, 32'h0000_0291);

    // R7 crystal stops -> fallback
    xrun = 0;
    tick(90);
    cmp("R7 select cleared", 32'(src_sel), 32'd0);
    rd_chk("R7 sticky flag", 1'b1, 32'h2);

    // R9 write-one-to-clear
    wr(1'b1, 32'h0000_0001);
    rd_chk("R9 write 0 keeps flag", 1'b1, 32'h2);
    wr(1'b1, 32'h0000_0002);
    rd_chk("R9 write 1 clears flag", 1'b1, 32'h0);

    // R8 bypass holds the selection on a dead crystal
    wr(1'b0, 32'h16AA_8011);
    tick(90);
    cmp("R8 select held", 32'(src_sel), 32'd1);
    rd_chk("R8 status ok low flag clear", 1'b1, 32'h0);
    cmp("R11 valid low on dead crystal", 32'(clk_valid), 32'd0);

    // crystal returns
    xrun = 1;
    tick(30);
    rd_chk("R6 crystal alive again", 1'b1, 32'h1);

    // R12 keyed write in the cycle the fallback is due
    wr(1'b0, 32'h16AA_0011);
    tick(20);
    xrun = 0;
    for (int i = 0; i < 200; i++) begin
      if (!xtal_ok) break;
      tick(1);
    end
    wr(1'b0, 32'h16AA_8011);
    tick(3);
    cmp("R12 write beats fallback", 32'(src_sel), 32'd1);
    rd_chk("R12 no flag", 1'b1, 32'h0);

    // R3 disabling the crystal
    wr(1'b0, 32'h16AA_0000);
    tick(3);
    cmp("R3 enable off", 32'(xtal_osc_en), 32'd0);
    rd_chk("R6 ok low when disabled", 1'b1, 32'h0);
    tick(10);

    done = 1;
    summary();
    $finish;
  end
endmodule